// File: doc/BRIEF.md
# Counter-Gated Serial Shift Engine

This block is an eight-bit synchronous serial shifter driven by an externally supplied serial clock. A processor write to the data register loads a byte and restarts a four-bit pulse counter. The engine then presents the byte most significant bit first on the serial output, samples the serial input, and shifts once per serial clock pulse. When the counter reaches eight, its top bit cuts off further shifting and counting. The same event raises an interrupt on the falling edge of the eighth pulse. The processor then reads the received byte back from the data register.

The serial clock comes in asynchronously. It passes through a synchroniser into the system clock domain, and its rising and falling edges are detected there. The serial input is sampled on rising edges. The register shifts, and the serial output changes, on falling edges. The output enable is high only while a transfer is in progress. The interrupt flag stays set until the processor writes the data register again or makes an access to the interrupt-off address.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, irq and dout_oe are 0 and reg_rdata and dout are 0.
- R2: A write with reg_addr = 0 (data register) loads reg_wdata into the shift register. From the next clock the value reads back on reg_rdata, and dout shows bit 7 of it.
- R3: Data leaves most significant bit first. After the k-th falling serial clock edge of a transfer (k = 1..7), dout carries bit 7-k of the loaded byte.
- R4: din is sampled on each rising serial clock edge and enters at bit 0 on the following falling edge. After eight pulses, reg_rdata holds the received bits with the first one at bit 7.
- R5: A transfer is exactly eight pulses. Further serial clock pulses leave reg_rdata, dout and irq unchanged and keep dout_oe at 0.
- R6: irq rises on the eighth falling edge of a transfer and not on any earlier edge.
- R7: Once set, irq stays high until a write with reg_addr = 1 (interrupt off) or reg_addr = 0 (data write) clears it. The interrupt-off access leaves reg_rdata unchanged.
- R8: A data write in the middle of a transfer abandons it. The engine loads the new byte and restarts the count, so irq appears only after eight more pulses.
- R9: Serial clock pulses after reset with no data write cause no shift, no output enable and no interrupt.
- R10: dout_oe is 1 from the clock after a data write until the eighth falling edge takes effect, and 0 otherwise.
- R11: With two synchroniser stages, a serial clock level change first acts on the design's registers at the third rising system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | External serial clock, asynchronous |
| din | input | 1 | Serial data input |
| reg_wr | input | 1 | Processor write strobe |
| reg_addr | input | 1 | 0 = data register, 1 = interrupt-off access |
| reg_wdata | input | 8 | Processor write data |
| reg_rdata | output | 8 | Shift register contents |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Tristate enable for dout |
| irq | output | 1 | Transfer-complete interrupt flag |

## Verification
A processor write takes effect on the next rising clock edge. The bench drives each write from one falling clock edge and samples the result at the following falling edge. A serial clock level change acts on the design at the third rising edge after it. Around the eighth falling edge, the bench reads irq at the falling edge after the second rising edge, where it must still be low, and again after the third, where it must be high. Each serial clock level is held for four system clocks. This lets every other per-bit result settle before it is read at the next falling clock edge.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
  // processor address decode (R2, R7)
  localparam logic ADDR_DATA    = 1'b0;
  localparam logic ADDR_IRQ_OFF = 1'b1;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/spi_sclk_sync.sv
`timescale 1ns/1ps
module spi_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_in,
  output spi_eng_pkg::sclk_edge_t  edges
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = sclk_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], sclk_in};
    end
  endgenerate

  assign synced = chain_q[STAGES-1];
  assign prev_d = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  always_comb begin
    edges.rise = synced & ~prev_q;
    edges.fall = ~synced & prev_q;
  end
endmodule

// File: rtl/spi_bit_ctr.sv
`timescale 1ns/1ps
module spi_bit_ctr #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic fall,
  output logic active,
  output logic last
);
  // DATA_W is a power of two; the top counter bit is the gate
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-2:0] LAST_LOW = (CNT_W-1)'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign active = ~cnt_q[CNT_W-1];
  assign last   = active & (cnt_q[CNT_W-2:0] == LAST_LOW);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (fall && active)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= IDLE_CNT;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_reg.sv
`timescale 1ns/1ps
module spi_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              active,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              smp_q, smp_d;

  always_comb begin
    sr_d  = sr_q;
    smp_d = smp_q;
    if (load) begin
      sr_d = load_data;
    end else if (active) begin
      if (rise) smp_d = din;
      if (fall) sr_d  = {sr_q[DATA_W-2:0], smp_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      smp_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      smp_q <= smp_d;
    end
  end

  assign q = sr_q;
endmodule

// File: rtl/spi_irq_ctl.sv
`timescale 1ns/1ps
module spi_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr)      flag_d = 1'b0;
    else if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q;
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              din,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dout,
  output logic              dout_oe,
  output logic              irq
);
  import spi_eng_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sclk_edge_t        edges;
  logic              data_wr;
  logic              irq_off;
  logic              active;
  logic              last;
  logic              done_evt;
  logic [DATA_W-1:0] sr;

  assign data_wr  = reg_wr & (reg_addr == ADDR_DATA);
  assign irq_off  = reg_wr & (reg_addr == ADDR_IRQ_OFF);
  assign done_evt = edges.fall & last & ~data_wr;

  spi_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sclk_in (sclk_in),
    .edges   (edges)
  );

  spi_bit_ctr #(.DATA_W(DATA_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (data_wr),
    .fall    (edges.fall),
    .active  (active),
    .last    (last)
  );

  spi_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (data_wr),
    .load_data (reg_wdata),
    .active    (active),
    .rise      (edges.rise),
    .fall      (edges.fall),
    .din       (din),
    .q         (sr)
  );

  spi_irq_ctl u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (done_evt),
    .clr   (data_wr | irq_off),
    .irq   (irq)
  );

  assign reg_rdata = sr;
  assign dout      = sr[DATA_W-1];
  assign dout_oe   = active;
endmodule

// File: rtl/spi_shift_engine_chk.sv
`timescale 1ns/1ps
module spi_shift_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              dout_oe,
  input logic              irq
);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == spi_eng_pkg::ADDR_DATA) |=> reg_rdata == $past(reg_wdata));

  // R10
  oe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == spi_eng_pkg::ADDR_DATA) |=> dout_oe);

  // R5
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_oe && !reg_wr) |=> $stable(reg_rdata));

  // R6
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !dout_oe);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !irq);
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .dout_oe   (dout_oe),
  .irq       (irq)
);

// File: tb/spi_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shift_engine_tb_top;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_in = 1'b0;
  logic       din = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       dout, dout_oe, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spi_shift_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .din(din),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dout(dout), .dout_oe(dout_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic addr, input logic [7:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic bit_in);
    @(negedge clk);
    din = bit_in;
    repeat (HOLD) @(negedge clk);
    sclk_in = 1'b1;
    repeat (HOLD) @(negedge clk);
    sclk_in = 1'b0;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 oe", {7'd0, dout_oe}, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 dout", {7'd0, dout}, 8'h00);
  endtask

  task automatic t_idle_edges;
    pulse(1'b1);
    pulse(1'b1);
    check("R9 rdata", reg_rdata, 8'h00);
    check("R9 oe", {7'd0, dout_oe}, 8'h00);
    check("R9 irq", {7'd0, irq}, 8'h00);
  endtask

  // full transfer; the eighth falling edge is timed cycle by cycle
  task automatic t_xfer(input logic [7:0] tx, input logic [7:0] rx);
    write_reg(1'b0, tx);
    check("R2 rdata", reg_rdata, tx);
    check("R10 oe on", {7'd0, dout_oe}, 8'h01);
    for (int k = 0; k < 7; k++) begin
      check("R3 dout", {7'd0, dout}, {7'd0, tx[7-k]});
      pulse(rx[7-k]);
      check("R6 no early irq", {7'd0, irq}, 8'h00);
    end
    check("R3 dout last", {7'd0, dout}, {7'd0, tx[0]});
    @(negedge clk);
    din = rx[0];
    repeat (HOLD) @(negedge clk);
    sclk_in = 1'b1;
    repeat (HOLD) @(negedge clk);
    sclk_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R11 irq not yet", {7'd0, irq}, 8'h00);
    check("R11 oe still on", {7'd0, dout_oe}, 8'h01);
    @(negedge clk);
    check("R6 irq on 8th fall", {7'd0, irq}, 8'h01);
    check("R10 oe off", {7'd0, dout_oe}, 8'h00);
    check("R4 rx byte", reg_rdata, rx);
  endtask

  task automatic t_extra_pulses(input logic [7:0] rx);
    pulse(~rx[7]);
    pulse(~rx[6]);
    pulse(1'b1);
    check("R5 rdata held", reg_rdata, rx);
    check("R5 dout held", {7'd0, dout}, {7'd0, rx[7]});
    check("R5 oe low", {7'd0, dout_oe}, 8'h00);
    check("R5 irq held", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_irq_off(input logic [7:0] rx);
    repeat (10) @(negedge clk);
    check("R7 irq sticky", {7'd0, irq}, 8'h01);
    write_reg(1'b1, 8'hFF);
    check("R7 irq cleared", {7'd0, irq}, 8'h00);
    check("R7 rdata kept", reg_rdata, rx);
  endtask

  task automatic t_restart;
    write_reg(1'b0, 8'hF0);
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    check("R3 mid dout", {7'd0, dout}, 8'h01);
    write_reg(1'b0, 8'h3C);
    check("R8 reload", reg_rdata, 8'h3C);
    for (int k = 0; k < 7; k++) pulse(k[0]);
    check("R8 no irq at 7", {7'd0, irq}, 8'h00);
    check("R8 oe at 7", {7'd0, dout_oe}, 8'h01);
    pulse(1'b1);
    check("R8 irq after 8", {7'd0, irq}, 8'h01);
    check("R8 rx byte", reg_rdata, 8'b01010101);
    write_reg(1'b0, 8'h81);
    check("R7 data write clears irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_idle_edges();
    t_xfer(8'hA5, 8'h3B);
    t_extra_pulses(8'h3B);
    t_irq_off(8'h3B);
    t_xfer(8'h01, 8'hFE);
    t_xfer(8'hFF, 8'h80);
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule